// File: doc/BRIEF.md
# Sector Address Translator

This block turns the four address bytes of a disk task file (drive/head select, cylinder high, cylinder low, sector) into a linear sector number. It then writes the address that follows a transfer back into the same four bytes, in whichever form the select byte asks for. Bit 6 of the select byte picks the form: logical block addressing (28 bits) or cylinder/head/sector. The address written back is the start address plus a transfer count. Drive geometry is supplied as inputs: heads per cylinder and sectors per track.

A controller pulses `start` with the current register values, the count, the geometry and the drive capacity. LBA requests finish in the next cycle. A CHS request needs two divisions, which share one sequential divider, so it holds `busy` for a little more than twice the address width in cycles. When the new register bytes are valid, the block gives a one-cycle `done` pulse. At that pulse an out-of-range flag reports whether the resulting address is unusable.

Top module: `sector_addr_xlate`

## Requirements
- R1: When select bit 6 is 1 (LBA), `lin_start` equals {select[3:0], cyl_hi, cyl_lo, sector}, with select[3:0] in bits 27:24 and sector in bits 7:0.
- R2: When select bit 6 is 0 (CHS), `lin_start` equals ((cylinder × heads) + head) × spt + sector − 1, taken modulo 2^28. Here cylinder = {cyl_hi, cyl_lo} and head = select[3:0].
- R3: `lin_next` equals the decoded start address plus `xfer_cnt`, modulo 2^28.
- R4: In LBA mode the write-back places target bits 27:24 in select[3:0], 23:16 in cyl_hi, 15:8 in cyl_lo and 7:0 in sector. Select bits 7:4 keep their input value.
- R5: In CHS mode the target T is written back as follows. The cylinder T / (heads × spt) goes to {cyl_hi, cyl_lo}. The head (T mod (heads × spt)) / spt goes to select[3:0], and select[7:4] is kept. The sector field gets (T mod spt-cylinder remainder mod spt) + 1.
- R6: A heads input of 0 is treated as 16 heads, and an spt input of 0 is treated as 63 sectors per track. Legal heads values are 1 to 16.
- R7: `out_of_range` is 1 at `done` when the target (start + count, 32-bit) is at or above `capacity`.
- R8: In CHS mode a sector field of 0 sets `out_of_range`.
- R9: In CHS mode a target cylinder above 16383 sets `out_of_range`.
- R10: An LBA request raises `done` in the cycle after `start` without raising `busy`. A CHS request holds `busy` until `done`. `busy` is low whenever `done` is high.
- R11: A `start` while `busy` is high is ignored, and the outputs reflect only the accepted request.
- R12: After reset, `busy`, `done`, `out_of_range` and all address outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse, accepted when not busy |
| sel_in | input | 8 | Drive/head select byte; bit 6 chooses LBA |
| cyl_hi_in | input | 8 | Cylinder high byte |
| cyl_lo_in | input | 8 | Cylinder low byte |
| sec_in | input | 8 | Sector byte |
| xfer_cnt | input | 9 | Sectors moved (0 to 256) |
| heads_in | input | 5 | Heads per cylinder, 0 means default |
| spt_in | input | 8 | Sectors per track, 0 means default |
| capacity | input | 28 | Drive size in sectors |
| busy | output | 1 | CHS division in progress |
| done | output | 1 | One-cycle pulse, write-back valid |
| sel_out | output | 8 | Written-back select byte |
| cyl_hi_out | output | 8 | Written-back cylinder high |
| cyl_lo_out | output | 8 | Written-back cylinder low |
| sec_out | output | 8 | Written-back sector |
| lin_start | output | 28 | Decoded start address |
| lin_next | output | 28 | Start plus count |
| out_of_range | output | 1 | Target address unusable |

## Verification
Two conditions are the hardest to reach from the ports. The first is a CHS target whose cylinder passes the 16383 limit while the capacity still admits it. The stimulus reaches it by placing the start address on the last sector of the last head of cylinder 16383 and moving one sector. The second is a request landing in the middle of the two-stage division. The bench reaches it by pulsing a conflicting LBA request a few cycles into a CHS request, then checking that the CHS result arrives unchanged. Carries across every field boundary (sector into head, head into cylinder, and LBA bits into the select nibble) are driven from table entries chosen to sit just below each boundary.

// File: rtl/sector_xlate_pkg.sv
package sector_xlate_pkg;

  localparam int REG_W   = 8;
  localparam int LBA_BIT = 6;
  localparam int LBA_W   = 28;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CYL,
    ST_HEAD
  } xl_state_e;

  // Linear number held in a 28-bit logical address spread over four bytes.
  function automatic logic [31:0] lba_linear(input logic [7:0] sel,
                                             input logic [7:0] chi,
                                             input logic [7:0] clo,
                                             input logic [7:0] sec);
    return {4'h0, sel[3:0], chi, clo, sec};
  endfunction

  // Linear number of a cylinder/head/sector triple (sectors count from 1).
  function automatic logic [31:0] chs_linear(input logic [15:0] cyl,
                                             input logic [3:0]  head,
                                             input logic [7:0]  sec,
                                             input logic [7:0]  heads,
                                             input logic [7:0]  spt);
    logic [31:0] track;
    track = 32'(cyl) * 32'(heads) + 32'(head);
    return track * 32'(spt) + 32'(sec) - 32'd1;
  endfunction

endpackage

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int W = 28
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quot,
  output logic [W-1:0] rem,
  output logic [W-1:0] num_q,
  output logic [W-1:0] den_q
);

  localparam int CW = $clog2(W + 1);

  logic [CW-1:0] cnt;
  logic [W-1:0]  rem_r, quot_r;
  logic [W:0]    trial, diff;
  logic          fits;

  // One restoring step: bring down the next dividend bit, subtract if it fits.
  assign trial = {rem_r, quot_r[W-1]};
  assign diff  = trial - {1'b0, den_q};
  assign fits  = trial >= {1'b0, den_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      rem_r  <= '0;
      quot_r <= '0;
      num_q  <= '0;
      den_q  <= '0;
      done   <= 1'b0;
    end else if (start) begin
      cnt    <= CW'(W);
      rem_r  <= '0;
      quot_r <= dividend;
      num_q  <= dividend;
      den_q  <= divisor;
      done   <= 1'b0;
    end else if (cnt != '0) begin
      rem_r  <= fits ? diff[W-1:0] : trial[W-1:0];
      quot_r <= {quot_r[W-2:0], fits};
      cnt    <= cnt - 1'b1;
      done   <= (cnt == CW'(1));
    end else begin
      done   <= 1'b0;
    end
  end

  assign busy = (cnt != '0);
  assign quot = quot_r;
  assign rem  = rem_r;

endmodule

// File: rtl/addr_decode.sv
module addr_decode
  import sector_xlate_pkg::*;
#(
  parameter int HEAD_W    = 5,
  parameter int SPT_W     = 8,
  parameter int DEF_HEADS = 16,
  parameter int DEF_SPT   = 63
) (
  input  logic [REG_W-1:0]  sel,
  input  logic [REG_W-1:0]  chi,
  input  logic [REG_W-1:0]  clo,
  input  logic [REG_W-1:0]  sec,
  input  logic [HEAD_W-1:0] heads_in,
  input  logic [SPT_W-1:0]  spt_in,
  output logic [31:0]       lin,
  output logic [HEAD_W-1:0] heads_eff,
  output logic [SPT_W-1:0]  spt_eff,
  output logic              lba_mode,
  output logic              bad_sector
);

  assign heads_eff  = (heads_in == '0) ? HEAD_W'(DEF_HEADS) : heads_in;
  assign spt_eff    = (spt_in == '0)   ? SPT_W'(DEF_SPT)    : spt_in;
  assign lba_mode   = sel[LBA_BIT];
  assign bad_sector = !lba_mode && (sec == '0);

  always_comb begin
    if (lba_mode)
      lin = lba_linear(sel, chi, clo, sec);
    else
      lin = chs_linear({chi, clo}, sel[3:0], sec, 8'(heads_eff), 8'(spt_eff));
  end

endmodule

// File: rtl/sector_addr_xlate.sv
module sector_addr_xlate
  import sector_xlate_pkg::*;
#(
  parameter int LIN_W     = 28,
  parameter int CNT_W     = 9,
  parameter int HEAD_W    = 5,
  parameter int SPT_W     = 8,
  parameter int DEF_HEADS = 16,
  parameter int DEF_SPT   = 63,
  parameter int MAX_CYL   = 16383
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        sel_in,
  input  logic [7:0]        cyl_hi_in,
  input  logic [7:0]        cyl_lo_in,
  input  logic [7:0]        sec_in,
  input  logic [CNT_W-1:0]  xfer_cnt,
  input  logic [HEAD_W-1:0] heads_in,
  input  logic [SPT_W-1:0]  spt_in,
  input  logic [LIN_W-1:0]  capacity,
  output logic              busy,
  output logic              done,
  output logic [7:0]        sel_out,
  output logic [7:0]        cyl_hi_out,
  output logic [7:0]        cyl_lo_out,
  output logic [7:0]        sec_out,
  output logic [LIN_W-1:0]  lin_start,
  output logic [LIN_W-1:0]  lin_next,
  output logic              out_of_range
);

  localparam int GEO_W = HEAD_W + SPT_W;

  xl_state_e         state;
  logic [31:0]       dec_lin, target_wide;
  logic [HEAD_W-1:0] dec_heads, heads_q;
  logic [SPT_W-1:0]  dec_spt, spt_q;
  logic              dec_lba, dec_bad, accept, chs_q;
  logic [GEO_W-1:0]  geo_prod;
  logic [3:0]        sel_hi_q;

  logic              div_start, div_busy, div_done;
  logic [LIN_W-1:0]  div_a, div_b, div_quot, div_rem, div_num_q, div_den_q;

  addr_decode #(
    .HEAD_W(HEAD_W), .SPT_W(SPT_W), .DEF_HEADS(DEF_HEADS), .DEF_SPT(DEF_SPT)
  ) u_decode (
    .sel(sel_in), .chi(cyl_hi_in), .clo(cyl_lo_in), .sec(sec_in),
    .heads_in(heads_in), .spt_in(spt_in),
    .lin(dec_lin), .heads_eff(dec_heads), .spt_eff(dec_spt),
    .lba_mode(dec_lba), .bad_sector(dec_bad)
  );

  assign accept      = start && (state == ST_IDLE);
  assign target_wide = dec_lin + 32'(xfer_cnt);
  assign geo_prod    = GEO_W'(dec_heads) * GEO_W'(dec_spt);

  // First division splits off the cylinder, second splits head from sector.
  assign div_start = (accept && !dec_lba) || ((state == ST_CYL) && div_done);
  assign div_a     = (state == ST_IDLE) ? target_wide[LIN_W-1:0] : div_rem;
  assign div_b     = (state == ST_IDLE) ? LIN_W'(geo_prod) : LIN_W'(spt_q);

  seq_divider #(.W(LIN_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start),
    .dividend(div_a), .divisor(div_b),
    .busy(div_busy), .done(div_done),
    .quot(div_quot), .rem(div_rem),
    .num_q(div_num_q), .den_q(div_den_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      done         <= 1'b0;
      sel_out      <= '0;
      cyl_hi_out   <= '0;
      cyl_lo_out   <= '0;
      sec_out      <= '0;
      lin_start    <= '0;
      lin_next     <= '0;
      out_of_range <= 1'b0;
      sel_hi_q     <= '0;
      heads_q      <= '0;
      spt_q        <= '0;
      chs_q        <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            sel_hi_q     <= sel_in[7:4];
            heads_q      <= dec_heads;
            spt_q        <= dec_spt;
            chs_q        <= !dec_lba;
            lin_start    <= dec_lin[LIN_W-1:0];
            lin_next     <= target_wide[LIN_W-1:0];
            out_of_range <= (target_wide >= 32'(capacity)) || dec_bad;
            if (dec_lba) begin
              sel_out    <= {sel_in[7:4], target_wide[LBA_W-1:24]};
              cyl_hi_out <= target_wide[23:16];
              cyl_lo_out <= target_wide[15:8];
              sec_out    <= target_wide[7:0];
              done       <= 1'b1;
            end else begin
              state <= ST_CYL;
            end
          end
        end
        ST_CYL: begin
          if (div_done) begin
            cyl_hi_out <= div_quot[15:8];
            cyl_lo_out <= div_quot[7:0];
            if (div_quot > LIN_W'(MAX_CYL)) out_of_range <= 1'b1;
            state <= ST_HEAD;
          end
        end
        ST_HEAD: begin
          if (div_done) begin
            sel_out <= {sel_hi_q, div_quot[3:0]};
            sec_out <= 8'(div_rem) + 8'd1;
            done    <= 1'b1;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/sector_addr_xlate_chk.sv
module sector_addr_xlate_chk #(
  parameter int LIN_W  = 28,
  parameter int HEAD_W = 5,
  parameter int SPT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [7:0]        sel_in,
  input logic [7:0]        sec_in,
  input logic              busy,
  input logic              done,
  input logic [7:0]        sel_out,
  input logic [7:0]        sec_out,
  input logic              out_of_range,
  input logic [3:0]        sel_hi_q,
  input logic [HEAD_W-1:0] heads_q,
  input logic [SPT_W-1:0]  spt_q,
  input logic              chs_q,
  input logic [LIN_W-1:0]  lin_next,
  input logic              div_done,
  input logic [LIN_W-1:0]  div_quot,
  input logic [LIN_W-1:0]  div_rem,
  input logic [LIN_W-1:0]  div_num_q,
  input logic [LIN_W-1:0]  div_den_q
);

  localparam int PW = 2 * LIN_W;

  a_r10_lba_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && sel_in[6]) |=> (done && !busy));

  a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  a_r11_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(lin_next) && $stable(sel_hi_q)));

  a_r4_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (sel_out[7:4] == sel_hi_q));

  a_r5_head_range: assert property (@(posedge clk) disable iff (!rst_n)
    (done && chs_q) |-> (HEAD_W'(sel_out[3:0]) < heads_q));

  a_r5_sector_range: assert property (@(posedge clk) disable iff (!rst_n)
    (done && chs_q) |-> ((sec_out != 8'd0) && (SPT_W'(sec_out) <= spt_q)));

  a_r5_div_identity: assert property (@(posedge clk) disable iff (!rst_n)
    div_done |-> (PW'(div_quot) * PW'(div_den_q) + PW'(div_rem) == PW'(div_num_q)));

  a_r5_div_rem: assert property (@(posedge clk) disable iff (!rst_n)
    div_done |-> (div_rem < div_den_q));

  a_r8_bad_sector: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !sel_in[6] && (sec_in == 8'd0)) |=> out_of_range);

endmodule

bind sector_addr_xlate sector_addr_xlate_chk #(
  .LIN_W(LIN_W), .HEAD_W(HEAD_W), .SPT_W(SPT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .sel_in(sel_in), .sec_in(sec_in),
  .busy(busy), .done(done), .sel_out(sel_out), .sec_out(sec_out),
  .out_of_range(out_of_range), .sel_hi_q(sel_hi_q), .heads_q(heads_q),
  .spt_q(spt_q), .chs_q(chs_q), .lin_next(lin_next), .div_done(div_done),
  .div_quot(div_quot), .div_rem(div_rem), .div_num_q(div_num_q),
  .div_den_q(div_den_q)
);

// File: tb/test_sector_addr_xlate.sv
module test_sector_addr_xlate;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  sel_in = '0, cyl_hi_in = '0, cyl_lo_in = '0, sec_in = '0;
  logic [8:0]  xfer_cnt = '0;
  logic [4:0]  heads_in = '0;
  logic [7:0]  spt_in = '0;
  logic [27:0] capacity = '0;
  logic        busy, done, out_of_range;
  logic [7:0]  sel_out, cyl_hi_out, cyl_lo_out, sec_out;
  logic [27:0] lin_start, lin_next;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  sector_addr_xlate i_sector_addr_xlate (
    .clk(clk), .rst_n(rst_n), .start(start),
    .sel_in(sel_in), .cyl_hi_in(cyl_hi_in), .cyl_lo_in(cyl_lo_in), .sec_in(sec_in),
    .xfer_cnt(xfer_cnt), .heads_in(heads_in), .spt_in(spt_in), .capacity(capacity),
    .busy(busy), .done(done), .sel_out(sel_out), .cyl_hi_out(cyl_hi_out),
    .cyl_lo_out(cyl_lo_out), .sec_out(sec_out), .lin_start(lin_start),
    .lin_next(lin_next), .out_of_range(out_of_range)
  );

  // Fields: sel, cyl_hi, cyl_lo, sec, heads, spt, count, capacity
  localparam int NV = 13;
  localparam logic [81:0] VEC [NV] = '{
    {8'hE5, 8'h12, 8'h34, 8'h56, 5'd16, 8'd63, 9'd1,   28'hFFFFFFF}, // R1 plain LBA
    {8'hF0, 8'hFF, 8'hFF, 8'hFF, 5'd16, 8'd63, 9'd1,   28'hFFFFFFF}, // R4 carry into select nibble
    {8'hA0, 8'h00, 8'h00, 8'h01, 5'd16, 8'd63, 9'd0,   28'hFFFFFFF}, // R2 first sector
    {8'hA3, 8'h01, 8'h02, 8'h3F, 5'd16, 8'd63, 9'd1,   28'hFFFFFFF}, // R5 sector wraps to next head
    {8'hAF, 8'h00, 8'h07, 8'h3F, 5'd16, 8'd63, 9'd1,   28'hFFFFFFF}, // R5 head wraps to next cylinder
    {8'hA2, 8'h00, 8'h05, 8'h0A, 5'd0,  8'd0,  9'd256, 28'hFFFFFFF}, // R6 default geometry
    {8'hA3, 8'h00, 8'h64, 8'h11, 5'd4,  8'd17, 9'd8,   28'hFFFFFFF}, // R5 small geometry
    {8'hE0, 8'h00, 8'h00, 8'h0F, 5'd16, 8'd63, 9'd1,   28'h0000010}, // R7 target equals capacity
    {8'hE0, 8'h00, 8'h00, 8'h0F, 5'd16, 8'd63, 9'd1,   28'h0000011}, // R7 last usable sector
    {8'hA0, 8'h00, 8'h00, 8'h00, 5'd16, 8'd63, 9'd1,   28'hFFFFFFF}, // R8 sector zero
    {8'hAF, 8'h3F, 8'hFF, 8'h3F, 5'd16, 8'd63, 9'd1,   28'hFFFFFFF}, // R9 cylinder past limit
    {8'h40, 8'h0A, 8'hBC, 8'hDE, 5'd16, 8'd63, 9'd0,   28'h0100000}, // R3 zero count
    {8'hA1, 8'h00, 8'h03, 8'h01, 5'd2,  8'd1,  9'd5,   28'hFFFFFFF}  // R5 one sector per track
  };

  task automatic chk(input string req, input longint act, input longint exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // Independent model of the requirements.
  task automatic model(input logic [81:0] v, output logic [27:0] e_start,
                       output logic [27:0] e_next, output logic [7:0] e_sel,
                       output logic [7:0] e_chi, output logic [7:0] e_clo,
                       output logic [7:0] e_sec, output logic e_oor);
    longint s8, ch, cl, sc, h, t, cnt, cap, lin, tgt32, tn, cyl, r;
    bit lba;
    s8 = v[81:74]; ch = v[73:66]; cl = v[65:58]; sc = v[57:50];
    h = (v[49:45] == 0) ? 16 : v[49:45];
    t = (v[44:37] == 0) ? 63 : v[44:37];
    cnt = v[36:28]; cap = v[27:0];
    lba = v[80];
    if (lba) lin = (s8 % 16) * 16777216 + ch * 65536 + cl * 256 + sc;
    else     lin = ((ch * 256 + cl) * h + (s8 % 16)) * t + sc - 1;
    lin   = lin & 64'hFFFFFFFF;
    tgt32 = (lin + cnt) & 64'hFFFFFFFF;
    tn    = tgt32 & 64'hFFFFFFF;
    e_start = 28'(lin);
    e_next  = 28'(tn);
    e_oor   = (tgt32 >= cap) || (!lba && sc == 0);
    if (lba) begin
      e_sel = 8'((s8 / 16) * 16 + tn / 16777216);
      e_chi = 8'(tn / 65536); e_clo = 8'(tn / 256); e_sec = 8'(tn);
    end else begin
      cyl = tn / (h * t);
      r   = tn % (h * t);
      e_sel = 8'((s8 / 16) * 16 + ((r / t) % 16));
      e_chi = 8'(cyl / 256); e_clo = 8'(cyl); e_sec = 8'(r % t + 1);
      if (cyl > 16383) e_oor = 1'b1;
    end
  endtask

  task automatic apply(input logic [81:0] v);
    sel_in = v[81:74]; cyl_hi_in = v[73:66]; cyl_lo_in = v[65:58]; sec_in = v[57:50];
    heads_in = v[49:45]; spt_in = v[44:37]; xfer_cnt = v[36:28]; capacity = v[27:0];
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int k = 0; k < 200; k++) begin
      if (done) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic check_result(input logic [81:0] v, input string tag);
    logic [27:0] es, en;
    logic [7:0]  a, b, c, d;
    logic        o;
    bit lba;
    model(v, es, en, a, b, c, d, o);
    lba = v[80];
    chk({tag, lba ? " R1 lin_start" : " R2 lin_start"}, lin_start, es);
    chk({tag, " R3 lin_next"}, lin_next, en);
    chk({tag, lba ? " R4 sel" : " R5 sel"}, sel_out, a);
    chk({tag, lba ? " R4 cyl" : " R5 cyl"}, {cyl_hi_out, cyl_lo_out}, {b, c});
    chk({tag, lba ? " R4 sec" : " R5 sec"}, sec_out, d);
    chk({tag, " R7/R8/R9 out_of_range"}, out_of_range, o);
  endtask

  task automatic run_vec(input logic [81:0] v, input string tag);
    bit ok;
    @(negedge clk);
    apply(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    chk({tag, " R10 done seen"}, ok, 1);
    check_result(v, tag);
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++;
        tests++;
        $display("FAIL watchdog R10 act=%0d exp=<100000", cycles);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin : stim
    bit ok;
    repeat (3) @(negedge clk);
    // R12: reset values
    chk("R12 busy", busy, 0);
    chk("R12 done", done, 0);
    chk("R12 out_of_range", out_of_range, 0);
    chk("R12 regs", {sel_out, cyl_hi_out, cyl_lo_out, sec_out}, 0);
    chk("R12 lin", {lin_start, lin_next}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], $sformatf("vec%0d", i));

    // R10: LBA finishes the cycle after start, busy never rises
    @(negedge clk);
    apply(VEC[0]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 lba done next cycle", done, 1);
    chk("R10 lba not busy", busy, 0);
    @(negedge clk);
    chk("R10 done single pulse", done, 0);

    // R10: CHS holds busy while dividing
    @(negedge clk);
    apply(VEC[6]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R10 chs busy", busy, 1);
    chk("R10 chs not done yet", done, 0);
    // R11: conflicting LBA request mid-division is dropped
    repeat (3) @(negedge clk);
    apply(VEC[1]);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    apply(VEC[6]);
    wait_done(ok);
    chk("R11 done seen", ok, 1);
    chk("R10 busy low at done", busy, 0);
    check_result(VEC[6], "R11 ignored start");
    repeat (4) @(negedge clk);
    chk("R11 no second done", done, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule